// File: doc/BRIEF.md
# Per-Channel Service Request Aggregator

This block gathers event requests from up to sixteen serial channels into five request bitmaps, one bit per channel in each. The five event classes are error, input ready, output space, modem change and command done. A pulse on a channel's event input sets that channel's bit in the matching bitmap. The bit then holds until the host collects it.

The host collects a bitmap through a small register bus. A read of a bitmap address returns the word and empties it in the same access, so a polling loop never needs a separate clear. An event that lands in that same cycle is kept for the next read.

A single doorbell interrupt tells the host that work is waiting. The host clears the doorbell by writing a 1 to a doorbell register. It then writes an acknowledge code to a global command register. If requests are still outstanding at that moment, the acknowledge raises the doorbell again.

Top module: `srq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every bitmap is empty, `irq_o` is low and `host_rdata_o` is zero.
- R2: A one-cycle pulse on bit n of an event input sets bit n of its bitmap. Bits that are already set stay set until that bitmap is read. The classes are independent of each other.
- R3: A read (`host_rd_i` high) returns the bitmap on `host_rdata_o` from the next cycle, zero-extended to 32 bits. The same read empties the bitmap. The bitmap addresses are 0 error, 1 input, 2 output, 3 modem and 4 command.
- R4: An event arriving in the same cycle as the read of its bitmap is not part of the returned value. It stays set in the bitmap afterwards, so the next read returns it.
- R5: `irq_o` goes high in the cycle after the clock edge at which the five bitmaps together go from all empty to not empty.
- R6: Once high, `irq_o` stays high even after the bitmaps are emptied. It falls only after a write to address 5 with bit 0 set. A write there with bit 0 clear has no effect.
- R7: A write of exactly 0x0001 to address 6 acknowledges service. If any bitmap is non-empty after that cycle, `irq_o` is high in the next cycle. Other values, and an acknowledge with nothing pending, leave `irq_o` unchanged.
- R8: When a doorbell clear falls in the same cycle as a doorbell raise, the raise wins and `irq_o` stays high.
- R9: A read of address 7 returns the interrupt status. Bit 13 shows the doorbell and every other bit is zero. In particular, none of the bits in mask 0x0810C000, which flag unexpected causes, are ever set.
- R10: A read of address 8 returns the board identifier 0x12.
- R11: A read of any other address returns zero. A read of any address other than 0 to 4 empties no bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ev_err_i | input | 16 | Per-channel error event pulses |
| ev_in_i | input | 16 | Per-channel input-ready event pulses |
| ev_out_i | input | 16 | Per-channel output-space event pulses |
| ev_mdm_i | input | 16 | Per-channel modem-change event pulses |
| ev_cmd_i | input | 16 | Per-channel command-done event pulses |
| host_rd_i | input | 1 | Host read strobe (read-and-clear on bitmap addresses) |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Doorbell interrupt |

## Verification
There are two kinds of collision to cover.

The first is an event pulse in the same cycle as the read-and-clear of its own bitmap. The bench provokes it by driving a modem event together with the read of the modem bitmap. It then judges two things: the returned word must hold only the older bit, and the following read must return the new one.

The second is a doorbell clear written in the same cycle that a fresh event raises the doorbell. Here `irq_o` must stay high. A cycle-by-cycle reference model runs alongside and compares `irq_o` and `host_rdata_o` on every clock, so any ordering slip in these collisions shows up at once.

// File: rtl/srq_pkg.sv
// Shared constants and register addresses for the service request aggregator.
package srq_pkg;
    localparam int NUM_CLS = 5;            // error, input, output, modem, command
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    typedef enum logic [ADDR_W-1:0] {
        ADR_ERR   = 4'd0,
        ADR_IN    = 4'd1,
        ADR_OUT   = 4'd2,
        ADR_MDM   = 4'd3,
        ADR_CMD   = 4'd4,
        ADR_DBCLR = 4'd5,
        ADR_GACK  = 4'd6,
        ADR_ISTAT = 4'd7,
        ADR_BTYPE = 4'd8
    } srq_addr_e;

    localparam logic [DATA_W-1:0] BOARD_ID   = 32'h0000_0012;
    localparam logic [DATA_W-1:0] ACK_CODE   = 32'h0000_0001;
    localparam logic [DATA_W-1:0] UNEXP_MASK = 32'h0810_C000;
    localparam int                DB_BIT     = 13;
endpackage

// File: rtl/srq_bitmap.sv
// One request bitmap: sticky per-channel bits with a read-and-clear.
// Assumes event inputs are single-cycle pulses. An event arriving in the
// clear cycle survives into the new value.
module srq_bitmap #(
    parameter int NUM_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] ev_i,
    input  logic              clr_i,
    output logic [NUM_CH-1:0] word_o,
    output logic [NUM_CH-1:0] word_next_o
);
    logic [NUM_CH-1:0] word_q;

    // Next value: clear on the exchange, then merge this cycle's events.
    always_comb begin
        word_next_o = (clr_i ? '0 : word_q) | ev_i;
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_next_o;
    end

    assign word_o = word_q;

    p_event_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_i != '0) |=> ((word_o & $past(ev_i)) == $past(ev_i)));
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> ((word_o & ~$past(ev_i)) == '0));
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((word_o & $past(word_o)) == $past(word_o)));
endmodule

// File: rtl/srq_doorbell.sv
// Doorbell flag: raised when the bitmaps leave the all-empty state, or
// by a global acknowledge while requests remain; dropped by a clear
// write. A raise beats a clear in the same cycle.
module srq_doorbell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic any_q_i,
    input  logic any_next_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic irq_o
);
    logic db_q;
    logic raise;

    // Raise on an empty-to-busy edge or on an acknowledge with work left.
    always_comb begin
        raise = (!any_q_i && any_next_i) || (ack_i && any_next_i);
    end

    // Doorbell flag register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    db_q <= 1'b0;
        else if (raise) db_q <= 1'b1;
        else if (clr_i) db_q <= 1'b0;
    end

    assign irq_o = db_q;

    p_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!any_q_i && any_next_i) |=> irq_o);
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr_i) |=> irq_o);
    p_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && any_next_i) |=> irq_o);
    p_raise_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !any_q_i && any_next_i) |=> irq_o);
endmodule

// File: rtl/srq_regif.sv
// Host read side: registered read data for bitmaps, interrupt status and
// board identifier. Holds its value between reads.
module srq_regif
    import srq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            rd_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0]  words_i,
    input  logic                            irq_i,
    output logic [DATA_W-1:0]               rdata_o
);
    logic [DATA_W-1:0] rmux;
    logic [DATA_W-1:0] rdata_q;

    // Read multiplexer over bitmaps and fixed registers.
    always_comb begin
        rmux = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (addr_i == ADDR_W'(c)) rmux = DATA_W'(words_i[c]);
        end
        if (addr_i == ADR_ISTAT) rmux[DB_BIT] = irq_i;
        if (addr_i == ADR_BTYPE) rmux = BOARD_ID;
    end

    // Read data register, loaded on each read strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   rdata_q <= '0;
        else if (rd_i) rdata_q <= rmux;
    end

    assign rdata_o = rdata_q;

    p_no_unexpected_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADR_ISTAT) |=> ((rdata_o & UNEXP_MASK) == '0));
    p_board_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADR_BTYPE) |=> (rdata_o == BOARD_ID));
    p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i > ADR_BTYPE) |=> (rdata_o == '0));
endmodule

// File: rtl/srq_aggregator.sv
// Top: five per-channel request bitmaps, doorbell interrupt and host
// register access. Assumes at most 16 channels and one host access per
// cycle.
module srq_aggregator
    import srq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] ev_err_i,
    input  logic [NUM_CH-1:0] ev_in_i,
    input  logic [NUM_CH-1:0] ev_out_i,
    input  logic [NUM_CH-1:0] ev_mdm_i,
    input  logic [NUM_CH-1:0] ev_cmd_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              irq_o
);
    logic [NUM_CLS-1:0][NUM_CH-1:0] ev;
    logic [NUM_CLS-1:0][NUM_CH-1:0] words;
    logic [NUM_CLS-1:0][NUM_CH-1:0] words_next;
    logic any_q, any_next, db_clr, g_ack;

    // Event classes in bitmap-address order.
    always_comb begin
        ev[0] = ev_err_i;
        ev[1] = ev_in_i;
        ev[2] = ev_out_i;
        ev[3] = ev_mdm_i;
        ev[4] = ev_cmd_i;
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_map
        srq_bitmap #(.NUM_CH(NUM_CH)) u_map (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ev_i       (ev[c]),
            .clr_i      (host_rd_i && host_addr_i == ADDR_W'(c)),
            .word_o     (words[c]),
            .word_next_o(words_next[c])
        );
    end

    // Pending summary and host write decode.
    always_comb begin
        any_q    = |words;
        any_next = |words_next;
        db_clr   = host_wr_i && host_addr_i == ADR_DBCLR && host_wdata_i[0];
        g_ack    = host_wr_i && host_addr_i == ADR_GACK && host_wdata_i == ACK_CODE;
    end

    srq_doorbell u_db (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .any_q_i   (any_q),
        .any_next_i(any_next),
        .clr_i     (db_clr),
        .ack_i     (g_ack),
        .irq_o     (irq_o)
    );

    srq_regif #(.NUM_CH(NUM_CH)) u_rif (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rd_i   (host_rd_i),
        .addr_i (host_addr_i),
        .words_i(words),
        .irq_i  (irq_o),
        .rdata_o(host_rdata_o)
    );

    p_reset_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq_o && host_rdata_o == '0));
endmodule

// File: tb/srq_aggregator_tb.sv
`timescale 1ns/100ps
module srq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] e_err = '0, e_in = '0, e_out = '0, e_mdm = '0, e_cmd = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int          m_w [5];
    bit          m_db;
    logic [31:0] m_rdata;

    always #2.5 clk = ~clk;

    srq_aggregator dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ev_err_i(e_err), .ev_in_i(e_in), .ev_out_i(e_out),
        .ev_mdm_i(e_mdm), .ev_cmd_i(e_cmd),
        .host_rd_i(rd), .host_wr_i(wr), .host_addr_i(addr),
        .host_wdata_i(wdata), .host_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference, stepped on each rising edge.
    always @(posedge clk) begin
        int  nw [5];
        int  evv [5];
        bit  old_any, new_any, raise, clr;
        evv = '{int'(e_err), int'(e_in), int'(e_out), int'(e_mdm), int'(e_cmd)};
        if (!rst_n) begin
            foreach (m_w[i]) m_w[i] = 0;
            m_db = 0;
            m_rdata = '0;
        end else begin
            old_any = 0; new_any = 0;
            foreach (m_w[i]) begin
                old_any |= (m_w[i] != 0);
                nw[i] = ((rd && addr == i) ? 0 : m_w[i]) | evv[i];
                new_any |= (nw[i] != 0);
            end
            if (rd) begin
                if (addr < 5)       m_rdata = 32'(m_w[addr]);
                else if (addr == 7) m_rdata = m_db ? 32'h2000 : 32'h0;
                else if (addr == 8) m_rdata = 32'h12;
                else                m_rdata = 32'h0;
            end
            raise = (!old_any && new_any) || (wr && addr == 6 && wdata == 32'h1 && new_any);
            clr   = wr && addr == 5 && wdata[0];
            m_db  = raise ? 1'b1 : (clr ? 1'b0 : m_db);
            foreach (m_w[i]) m_w[i] = nw[i];
        end
    end

    // Compare with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5/R6 model irq", 32'(irq), 32'(m_db));
            chk("R3 model rdata", rdata, m_rdata);
        end
    end

    // One bus/event cycle, then idle inputs.
    task automatic cyc(input bit r, input bit w, input logic [3:0] a, input logic [31:0] d,
                       input logic [15:0] er, input logic [15:0] ei, input logic [15:0] eo,
                       input logic [15:0] em, input logic [15:0] ec);
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d;
        e_err = er; e_in = ei; e_out = eo; e_mdm = em; e_cmd = ec;
        @(negedge clk);
        rd = 0; wr = 0; addr = '0; wdata = '0;
        e_err = '0; e_in = '0; e_out = '0; e_mdm = '0; e_cmd = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a);
        cyc(1, 0, a, '0, '0, '0, '0, '0, '0);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        cyc(0, 1, a, d, '0, '0, '0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rdata", rdata, 0);
        for (int a = 0; a < 5; a++) begin
            rd_reg(4'(a));
            chk("R1 empty bitmap", rdata, 0);
        end
        // R5 raise, R2/R3 read and clear
        cyc(0, 0, 0, 0, '0, 16'h0008, '0, '0, '0);
        chk("R5 irq after first event", 32'(irq), 1);
        rd_reg(1);
        chk("R3 input bitmap", rdata, 32'h0008);
        rd_reg(1);
        chk("R3 emptied", rdata, 0);
        // R6 doorbell persistence and clear
        chk("R6 irq held while empty", 32'(irq), 1);
        wr_reg(5, 32'h0);
        chk("R6 zero write ignored", 32'(irq), 1);
        wr_reg(5, 32'h1);
        chk("R6 clear", 32'(irq), 0);
        // R2 accumulate and class independence
        cyc(0, 0, 0, 0, 16'h0001, '0, '0, '0, '0);
        cyc(0, 0, 0, 0, 16'h8000, '0, '0, '0, '0);
        rd_reg(0);
        chk("R2 accumulate", rdata, 32'h8001);
        cyc(0, 0, 0, 0, 16'h0101, 16'h0202, 16'h0404, 16'h0808, 16'h1010);
        rd_reg(0); chk("R2 err class", rdata, 32'h0101);
        rd_reg(1); chk("R2 in class", rdata, 32'h0202);
        rd_reg(2); chk("R2 out class", rdata, 32'h0404);
        rd_reg(3); chk("R2 mdm class", rdata, 32'h0808);
        rd_reg(4); chk("R2 cmd class", rdata, 32'h1010);
        // R4 event during exchange
        cyc(0, 0, 0, 0, '0, '0, '0, 16'h0004, '0);
        cyc(1, 0, 3, 0, '0, '0, '0, 16'h0020, '0);
        chk("R4 returned old word", rdata, 32'h0004);
        rd_reg(3);
        chk("R4 new event kept", rdata, 32'h0020);
        // R7 acknowledge
        wr_reg(5, 32'h1);
        cyc(0, 0, 0, 0, '0, '0, '0, '0, 16'h0080);
        chk("R5 irq on cmd", 32'(irq), 1);
        wr_reg(5, 32'h1);
        chk("R6 cleared with pending", 32'(irq), 0);
        wr_reg(6, 32'h1);
        chk("R7 ack re-raises", 32'(irq), 1);
        wr_reg(5, 32'h1);
        wr_reg(6, 32'h3);
        chk("R7 wrong code ignored", 32'(irq), 0);
        rd_reg(4);
        chk("R7 cmd word", rdata, 32'h0080);
        wr_reg(6, 32'h1);
        chk("R7 ack nothing pending", 32'(irq), 0);
        // R8 raise beats clear
        cyc(0, 1, 5, 32'h1, '0, '0, 16'h0002, '0, '0);
        chk("R8 raise wins", 32'(irq), 1);
        // R9 status
        rd_reg(7);
        chk("R9 status doorbell", rdata, 32'h2000);
        chk("R9 unexpected mask", rdata & 32'h0810C000, 0);
        wr_reg(5, 32'h1);
        rd_reg(7);
        chk("R9 status idle", rdata, 0);
        // R10 board id
        rd_reg(8);
        chk("R10 board id", rdata, 32'h12);
        // R11 unmapped and no side clear
        rd_reg(9);
        chk("R11 unmapped", rdata, 0);
        rd_reg(15);
        chk("R11 unmapped top", rdata, 0);
        rd_reg(2);
        chk("R11 output word untouched", rdata, 32'h0002);
        rd_reg(2);
        chk("R3 output emptied", rdata, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule